// File: doc/BRIEF.md
# Serial Write-Only Register Port

This block is a slave control port that takes register writes over a three-wire serial link. The three wires are an active-low select, a serial clock and a serial data input. There is no data output wire, so software can never read a register back through this port. The block retimes all three wires into the system clock domain. It frames each transfer from the fall of select and checks a fixed device address with a write bit. It then loads a register pointer and stores each following data byte into a small register file. The whole register file is driven out in parallel so that the rest of the device can use the settings.

A transfer is a device byte, then a pointer byte, then any number of data bytes. The top bit of the pointer byte decides how a burst behaves. When it is set, successive data bytes fill successive registers. When it is clear, every data byte lands on the same register. Raising select at any moment ends the transfer and throws away any byte that is not yet complete.

Top module: `spiwr_regport`

## Requirements
- R1: After reset, every register reads zero, the pointer is zero and auto-increment is off.
- R2: A data bit is taken on each rising edge of the serial clock while select is low, most significant bit first. Clock edges while select is high change nothing.
- R3: The first byte of a frame must be 0x20, which is the device address 0010000 followed by a write bit of 0. Any other value, including a read request (0x21), makes the port ignore the rest of the frame until select rises.
- R4: The second byte loads the pointer. Bits 6..0 give the register address and bit 7 is the auto-increment flag.
- R5: Each later complete byte is stored into the register the pointer selects. A pointer value of NUM_REGS (16) or more stores nothing, and all other registers keep their values.
- R6: With the flag at 1, the pointer advances by one after each data byte and wraps from 127 to 0. With the flag at 0, the pointer stays fixed.
- R7: Raising select aborts the frame. The partial byte is discarded and the bit count restarts, so the next frame is decoded from its first bit. A byte whose final clock edge arrives together with the rise of select is also discarded.
- R8: Register n appears on `regFlat` bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial bit clock, asynchronous to clk |
| serSelN | input | 1 | Active-low frame select |
| serData | input | 1 | Serial data in |
| regFlat | output | NUM_REGS*8 | All registers side by side, register 0 in the low byte |

## Verification
Two events can fall in the same system cycle: the rising clock edge that completes a data byte, and the rise of select that aborts the frame. The bench provokes this by raising the serial clock and select at the same instant for the eighth bit of a data byte. It then judges the outcome from the register outputs: that register must keep its old value, and the next ordinary frame must still write correctly. A second overlap occurs within a burst, where a write and a pointer advance share one cycle. That case is judged from the order in which the scoreboard sees registers change.

// File: rtl/spiwr_pkg.sv
package spiwr_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 7;

  typedef struct packed {
    logic              loadPtr;
    logic              writeByte;
    logic [BYTE_W-1:0] byteVal;
  } strobe_t;
endpackage

// File: rtl/spiwr_ctrl.sv
module spiwr_ctrl
  import spiwr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEVICE_ID   = 7'b0010000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serSelN,
  input  logic    serData,
  output strobe_t strb
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] WRITE_HDR = {DEVICE_ID, 1'b0};

  typedef enum logic [1:0] {FR_DEV, FR_PTR, FR_DATA, FR_SKIP} frame_e;

  logic [SYNC_STAGES-1:0] clkPipe, selPipe, datPipe;
  logic clkSync, selSync, datSync, clkPrev, riseEdge;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] fullByte;
  frame_e frameSt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkPipe <= '0; selPipe <= '1; datPipe <= '0;
        end else begin
          clkPipe <= serClk; selPipe <= serSelN; datPipe <= serData;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkPipe <= '0; selPipe <= '1; datPipe <= '0;
        end else begin
          clkPipe <= {clkPipe[SYNC_STAGES-2:0], serClk};
          selPipe <= {selPipe[SYNC_STAGES-2:0], serSelN};
          datPipe <= {datPipe[SYNC_STAGES-2:0], serData};
        end
      end
    end
  endgenerate

  assign clkSync  = clkPipe[SYNC_STAGES-1];
  assign selSync  = selPipe[SYNC_STAGES-1];
  assign datSync  = datPipe[SYNC_STAGES-1];
  assign riseEdge = clkSync & ~clkPrev & ~selSync;
  assign fullByte = {shiftReg, datSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      bitCnt   <= '0;
      shiftReg <= '0;
      frameSt  <= FR_DEV;
      strb     <= '0;
    end else begin
      clkPrev        <= clkSync;
      strb.loadPtr   <= 1'b0;
      strb.writeByte <= 1'b0;
      if (selSync) begin
        bitCnt   <= '0;
        shiftReg <= '0;
        frameSt  <= FR_DEV;
      end else if (riseEdge) begin
        shiftReg <= fullByte[BYTE_W-2:0];
        bitCnt   <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(BYTE_W-1)) begin
          unique case (frameSt)
            FR_DEV:  frameSt <= (fullByte == WRITE_HDR) ? FR_PTR : FR_SKIP;
            FR_PTR: begin
              strb.loadPtr <= 1'b1;
              strb.byteVal <= fullByte;
              frameSt      <= FR_DATA;
            end
            FR_DATA: begin
              strb.writeByte <= 1'b1;
              strb.byteVal   <= fullByte;
            end
            FR_SKIP: frameSt <= FR_SKIP;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spiwr_datapath.sv
module spiwr_datapath
  import spiwr_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  output logic [PTR_W-1:0]           ptr,
  output logic                       incr,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr  <= '0;
      incr <= 1'b0;
    end else if (strb.loadPtr) begin
      ptr  <= strb.byteVal[PTR_W-1:0];
      incr <= strb.byteVal[BYTE_W-1];
    end else if (strb.writeByte && incr) begin
      ptr <= ptr + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regFlat[g*BYTE_W +: BYTE_W] <= '0;
        else if (strb.writeByte && (ptr == PTR_W'(g)))
          regFlat[g*BYTE_W +: BYTE_W] <= strb.byteVal;
      end
    end
  endgenerate
endmodule

// File: rtl/spiwr_regport.sv
module spiwr_regport
  import spiwr_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEVICE_ID   = 7'b0010000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serClk,
  input  logic                       serSelN,
  input  logic                       serData,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat
);
  strobe_t           strb;
  logic [PTR_W-1:0]  ptr;
  logic              incr;

  spiwr_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DEVICE_ID(DEVICE_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serSelN(serSelN),
    .serData(serData), .strb(strb)
  );

  spiwr_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ptr(ptr), .incr(incr),
    .regFlat(regFlat)
  );
endmodule

// File: rtl/spiwr_regport_chk.sv
module spiwr_regport_chk
  import spiwr_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       serSelN,
  input strobe_t                    strb,
  input logic [PTR_W-1:0]           ptr,
  input logic                       incr,
  input logic [NUM_REGS*BYTE_W-1:0] regFlat
);
  function automatic logic [BYTE_W-1:0] regAt(input logic [NUM_REGS*BYTE_W-1:0] flat,
                                               input logic [PTR_W-1:0] idx);
    return (int'(idx) < NUM_REGS) ? flat[int'(idx)*BYTE_W +: BYTE_W] : '0;
  endfunction

  p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPtr |=> (ptr == $past(strb.byteVal[PTR_W-1:0])) && (incr == $past(strb.byteVal[BYTE_W-1])));

  p_ptr_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeByte && !incr && !strb.loadPtr) |=> $stable(ptr));

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeByte && incr && !strb.loadPtr) |=> ptr == PTR_W'($past(ptr) + 1'b1));

  p_write_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeByte && (int'(ptr) < NUM_REGS)) |=> regAt(regFlat, $past(ptr)) == $past(strb.byteVal));

  p_hold_regs_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeByte |=> $stable(regFlat));

  p_quiet_deselect_r7: assert property (@(posedge clk) disable iff (!rstN)
    (serSelN && $past(serSelN) && $past(serSelN, 2) && $past(serSelN, 3) && $past(serSelN, 4))
      |-> !(strb.loadPtr || strb.writeByte));
endmodule

bind spiwr_regport spiwr_regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .serSelN(serSelN), .strb(strb), .ptr(ptr),
  .incr(incr), .regFlat(regFlat)
);

// File: tb/spiwr_regport_tb.sv
module spiwr_regport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 40;
  localparam int NREG       = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic serClk = 1'b0, serSelN = 1'b1, serData = 1'b0;
  logic [NREG*8-1:0] regFlat, prevFlat;

  int total = 0, bad = 0, cycles = 0;
  bit started = 0, done = 0;
  logic [7:0] model [NREG];
  int qAddr[$];
  logic [7:0] qVal[$];

  spiwr_regport #(.NUM_REGS(NREG)) u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serSelN(serSelN),
    .serData(serData), .regFlat(regFlat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // monitor: pops expected writes as registers change (R5, R6, R8)
  always @(negedge clk) begin
    if (started) begin
      for (int i = 0; i < NREG; i++) begin
        if (regFlat[i*8 +: 8] !== prevFlat[i*8 +: 8]) begin
          total++;
          if (qAddr.size() == 0) begin
            bad++;
            $display("FAIL R5 unexpected write: reg%0d actual=%h expected=no change", i, regFlat[i*8 +: 8]);
          end else begin
            automatic int ea = qAddr.pop_front();
            automatic logic [7:0] ev = qVal.pop_front();
            if (ea != i || regFlat[i*8 +: 8] !== ev) begin
              bad++;
              $display("FAIL R5/R6/R8 write order: actual reg%0d=%h expected reg%0d=%h", i, regFlat[i*8 +: 8], ea, ev);
            end
          end
        end
      end
      prevFlat = regFlat;
    end
  end

  task automatic checkAll(input string tag);
    int mism = 0;
    total++;
    for (int i = 0; i < NREG; i++)
      if (regFlat[i*8 +: 8] !== model[i]) begin
        mism++;
        $display("FAIL %s: reg%0d actual=%h expected=%h", tag, i, regFlat[i*8 +: 8], model[i]);
      end
    if (qAddr.size() != 0) begin
      mism++;
      $display("FAIL %s: pending writes actual=%0d expected=0", tag, qAddr.size());
    end
    if (mism != 0) bad++;
  endtask

  task automatic bit1(input logic b);
    serData = b; serClk = 1'b0; #HALF;
    serClk = 1'b1; #HALF;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) bit1(b[k]);
  endtask

  task automatic frameBegin();
    serClk = 1'b0; serSelN = 1'b0; #HALF;
  endtask

  task automatic frameEnd();
    serClk = 1'b0; #HALF; serSelN = 1'b1; #(20*CLK_PERIOD);
  endtask

  // expected effect of a data byte per R4-R6
  task automatic expectByte(inout int p, input bit inc, input logic [7:0] v);
    if (p < NREG) begin
      if (model[p] !== v) begin qAddr.push_back(p); qVal.push_back(v); end
      model[p] = v;
    end
    if (inc) p = (p + 1) % 128;
  endtask

  task automatic burst(input logic [7:0] hdr, input logic [7:0] pb, input logic [7:0] d[], input bit good);
    int p = int'(pb[6:0]);
    frameBegin();
    sendByte(hdr); sendByte(pb);
    foreach (d[j]) begin
      if (good) expectByte(p, pb[7], d[j]);
      sendByte(d[j]);
    end
    frameEnd();
  endtask

  initial begin
    foreach (model[i]) model[i] = 8'h00;
    #(3*CLK_PERIOD + CLK_PERIOD/2);
    rstN = 1'b1;
    #(4*CLK_PERIOD);
    prevFlat = regFlat;
    started = 1;
    checkAll("R1 reset state");

    burst(8'h20, 8'h03, '{8'hA5}, 1);
    checkAll("R4 single write reg3");

    burst(8'h20, 8'h85, '{8'h11, 8'h22, 8'h33}, 1);
    checkAll("R6 incrementing burst 5..7");

    burst(8'h20, 8'h02, '{8'h44, 8'h55, 8'h66}, 1);
    checkAll("R6 fixed pointer burst reg2");

    burst(8'h22, 8'h04, '{8'h77}, 0);
    checkAll("R3 wrong device address ignored");

    burst(8'h21, 8'h04, '{8'h78}, 0);
    checkAll("R3 read request ignored");

    burst(8'h20, 8'h8F, '{8'h9A, 8'h9B}, 1);
    checkAll("R5 write past last register dropped");

    burst(8'h20, 8'hFF, '{8'hC1, 8'hC2}, 1);
    checkAll("R6 pointer wraps 127 to 0");

    // R2: clocking with select high changes nothing
    serSelN = 1'b1;
    for (int k = 0; k < 3; k++) sendByte(8'h20);
    serClk = 1'b0; #(20*CLK_PERIOD);
    checkAll("R2 clocks while deselected ignored");

    // R7: abort mid-byte, then a fresh frame decodes from bit 0
    frameBegin();
    sendByte(8'h20); sendByte(8'h08);
    bit1(1'b1); bit1(1'b0); bit1(1'b1); bit1(1'b1);
    frameEnd();
    checkAll("R7 mid-byte abort discards");
    burst(8'h20, 8'h08, '{8'h5C}, 1);
    checkAll("R7 frame after abort");

    // R7: final edge of a byte coincides with select rising
    frameBegin();
    sendByte(8'h20); sendByte(8'h09);
    for (int k = 7; k >= 1; k--) bit1(k[0]);
    serData = 1'b1; serClk = 1'b0; #HALF;
    serClk = 1'b1; serSelN = 1'b1; #HALF;
    serClk = 1'b0; #(20*CLK_PERIOD);
    checkAll("R7 collision of last edge and deselect");
    burst(8'h20, 8'h09, '{8'hE7}, 1);
    checkAll("R7 frame after collision");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule